// File: doc/BRIEF.md
# Serial Preamble and Start-of-Frame Detector

This block sits on a one-bit serial receive path, one sample per bit time, and qualifies each incoming frame before any other receive logic sees it. A frame is the run of clock cycles in which `rx_valid` is high. The block counts bit times from the first valid sample. It discards an initial settling window and then requires a short run of strictly alternating bits. After that run it looks for two consecutive ones, which mark the start-of-frame delimiter.

When the header is accepted, the block emits a one-cycle start-of-frame pulse. It then forwards every following bit with a strobe, so the header never reaches downstream logic. When the header is malformed, the block emits a one-cycle error pulse and stays silent until `rx_valid` drops. All outputs are registered and appear one clock after the sample that causes them. The window lengths are parameters. The defaults are 16 settling bits and 5 alternation bits.

Top module: `sfd_detect`

## Requirements
- R1: Bit times 1 to 16 of a frame (bit time 1 is the first cycle with `rx_valid` high) produce no output, whatever their values, including runs such as 1111 or 0000.
- R2: If any bit in bit times 18 to 21 equals the bit before it, `err_o` pulses for one cycle, one clock after that bit, and the frame produces no further output.
- R3: Bit time 17 is never compared with bit time 16, so equal values at bit times 16 and 17 are accepted.
- R4: From bit time 22 on, while the header is pending, a bit of 1 that follows a bit of 1 makes `sof_o` pulse one clock later. The pair may include bit time 21, so the earliest pulse follows bit time 22.
- R5: From bit time 22 on, while the header is pending, a bit of 0 that follows a bit of 0 makes `err_o` pulse one clock later and rejects the frame.
- R6: Every valid bit after the one that completed the delimiter gives `strobe_o` high one clock later, with `data_o` equal to that bit. Header bits are never strobed.
- R7: After a rejection, no `sof_o`, `strobe_o` or second `err_o` appears until `rx_valid` goes low, even if a valid-looking preamble and delimiter follow.
- R8: A cycle with `rx_valid` low produces no output one clock later, and the next valid bit counts as bit time 1. A single low cycle is enough to restart detection.
- R9: While `rst` is high, and in the first cycle after it, all outputs are low.
- R10: At most one of `sof_o`, `strobe_o` and `err_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bit time per cycle when valid |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive data qualifier; high for the duration of a frame |
| rx_bit | input | 1 | Serial receive data sample |
| sof_o | output | 1 | One-cycle pulse when the delimiter is recognised |
| strobe_o | output | 1 | High when `data_o` carries a payload bit |
| data_o | output | 1 | Payload bit, meaningful when `strobe_o` is high |
| err_o | output | 1 | One-cycle pulse when the header is rejected |

## Verification
The assertions assume that `rx_valid` and `rx_bit` change only between clock edges and take known values once reset is released. They also assume that a frame is nothing more than a contiguous run of high `rx_valid`, with no other framing signal. The stimulus drives both inputs on the falling edge. It holds `rx_bit` at random values during low `rx_valid` gaps to show that those bits are ignored. It varies the gap length down to a single cycle so that restarts stay within that assumption. Frames are built from random settling bits, alternating runs of random phase and length, optional single-bit corruptions and random delimiter choices.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int unsigned SKIP_BITS_DEF = 16;
    localparam int unsigned ALT_BITS_DEF  = 5;

    typedef enum logic [1:0] {
        PH_SKIP = 2'd0,
        PH_ALT  = 2'd1,
        PH_HUNT = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ST_HEADER  = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_DISCARD = 2'd2
    } state_e;

    typedef struct packed {
        logic same;
        logic ones;
    } pair_t;

    typedef struct packed {
        logic sof;
        logic strobe;
        logic bit_val;
        logic err;
    } rx_evt_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/sfd_bit_timer.sv
module sfd_bit_timer
    import sfd_pkg::*;
#(
    parameter int unsigned SKIP_BITS = SKIP_BITS_DEF,
    parameter int unsigned ALT_BITS  = ALT_BITS_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   valid,
    output phase_e phase,
    output logic   first_alt
);
    localparam int unsigned LIMIT = SKIP_BITS + ALT_BITS;
    localparam int unsigned CW    = cnt_width(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !valid) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        if (cnt < CW'(SKIP_BITS)) begin
            phase = PH_SKIP;
        end else if (cnt < CW'(LIMIT)) begin
            phase = PH_ALT;
        end else begin
            phase = PH_HUNT;
        end
        first_alt = (cnt == CW'(SKIP_BITS));
    end

    // R8: a low qualifier restarts bit-time counting
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (phase == PH_SKIP));

    // R4: the hunt phase is only left by a drop of the qualifier
    p_hunt_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HUNT) && valid |=> (phase == PH_HUNT));
endmodule

// File: rtl/sfd_pair_cmp.sv
module sfd_pair_cmp
    import sfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  logic  bit_in,
    output pair_t pair
);
    logic prev_bit;
    logic have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bit  <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            prev_bit  <= bit_in;
            have_prev <= valid;
        end
    end

    always_comb begin
        pair.same = have_prev && valid && (bit_in == prev_bit);
        pair.ones = pair.same && bit_in;
    end

    // R4: a ones pair needs the previous sample to be a valid one
    p_ones_needs_prev_r4: assert property (@(posedge clk) disable iff (rst)
        pair.ones |-> $past(valid) && $past(bit_in));
endmodule

// File: rtl/sfd_hdr_fsm.sv
module sfd_hdr_fsm
    import sfd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  logic    bit_in,
    input  phase_e  phase,
    input  logic    first_alt,
    input  pair_t   pair,
    output rx_evt_t evt
);
    state_e  st, st_nxt;
    rx_evt_t evt_nxt;

    always_comb begin
        st_nxt  = st;
        evt_nxt = '0;
        if (!valid) begin
            st_nxt = ST_HEADER;
        end else begin
            unique case (st)
                ST_HEADER: begin
                    unique case (phase)
                        PH_ALT: begin
                            if (!first_alt && pair.same) begin
                                evt_nxt.err = 1'b1;
                                st_nxt      = ST_DISCARD;
                            end
                        end
                        PH_HUNT: begin
                            if (pair.ones) begin
                                evt_nxt.sof = 1'b1;
                                st_nxt      = ST_PAYLOAD;
                            end else if (pair.same) begin
                                evt_nxt.err = 1'b1;
                                st_nxt      = ST_DISCARD;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_PAYLOAD: begin
                    evt_nxt.strobe  = 1'b1;
                    evt_nxt.bit_val = bit_in;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_HEADER;
            evt <= '0;
        end else begin
            st  <= st_nxt;
            evt <= evt_nxt;
        end
    end

    // R10: outputs are mutually exclusive
    p_single_event_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.sof, evt.strobe, evt.err}));

    // R1: nothing is reported for a settling-window bit
    p_skip_silent_r1: assert property (@(posedge clk) disable iff (rst)
        valid && (phase == PH_SKIP) |=> !evt.err && !evt.sof);

    // R7: a rejected frame stays silent
    p_discard_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        valid && (st == ST_DISCARD) |=> (evt == '0));

    // R8: a low qualifier gives no output
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (evt == '0));

    // R6: payload strobes never start before a start-of-frame
    p_strobe_after_sof_r6: assert property (@(posedge clk) disable iff (rst)
        evt.strobe |-> $past(evt.sof) || $past(evt.strobe));
endmodule

// File: rtl/sfd_detect.sv
module sfd_detect
    import sfd_pkg::*;
#(
    parameter int unsigned SKIP_BITS = SKIP_BITS_DEF,
    parameter int unsigned ALT_BITS  = ALT_BITS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_valid,
    input  logic rx_bit,
    output logic sof_o,
    output logic strobe_o,
    output logic data_o,
    output logic err_o
);
    phase_e  phase;
    logic    first_alt;
    pair_t   pair;
    rx_evt_t evt;

    sfd_bit_timer #(
        .SKIP_BITS (SKIP_BITS),
        .ALT_BITS  (ALT_BITS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .valid     (rx_valid),
        .phase     (phase),
        .first_alt (first_alt)
    );

    sfd_pair_cmp u_pair (
        .clk    (clk),
        .rst    (rst),
        .valid  (rx_valid),
        .bit_in (rx_bit),
        .pair   (pair)
    );

    sfd_hdr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .valid     (rx_valid),
        .bit_in    (rx_bit),
        .phase     (phase),
        .first_alt (first_alt),
        .pair      (pair),
        .evt       (evt)
    );

    assign sof_o    = evt.sof;
    assign strobe_o = evt.strobe;
    assign data_o   = evt.bit_val;
    assign err_o    = evt.err;

    // R4: start-of-frame follows two valid ones at the pins
    p_sof_pins_r4: assert property (@(posedge clk) disable iff (rst)
        sof_o |-> $past(rx_bit) && $past(rx_valid)
                  && $past(rx_bit, 2) && $past(rx_valid, 2));

    // R6: the forwarded bit is the sample from one clock earlier
    p_data_echo_r6: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> (data_o == $past(rx_bit)) && $past(rx_valid));
endmodule

// File: tb/tb_sfd_detect.sv
`timescale 1ns/1ps
module tb_sfd_detect;
    localparam int SKIP = 16;
    localparam int ALT  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic rx_bit = 1'b0;
    logic sof_o, strobe_o, data_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    fq[$];
    int    exp_c[$];
    bit    exp_b[$];
    string exp_t[$];

    sfd_detect #(.SKIP_BITS(SKIP), .ALT_BITS(ALT)) dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .sof_o(sof_o), .strobe_o(strobe_o), .data_o(data_o), .err_o(err_o)
    );

    always #4 clk = ~clk;

    // event codes: 0 none, 1 start-of-frame, 2 data bit, 3 header error
    task automatic check_out(input int code_e, input bit bit_e, input string tag);
        int code_a;
        code_a = sof_o ? 1 : strobe_o ? 2 : err_o ? 3 : 0;
        checks++;
        if (code_a != code_e || (code_e == 2 && data_o != bit_e)) begin
            errors++;
            $display("FAIL %s: event=%0d bit=%0b expected event=%0d bit=%0b",
                     tag, code_a, data_o, code_e, bit_e);
        end
        checks++;
        if ($countones({sof_o, strobe_o, err_o}) > 1) begin
            errors++;
            $display("FAIL R10: outputs=%b expected at most one high",
                     {sof_o, strobe_o, err_o});
        end
    endtask

    // reference model built from the requirements
    task automatic model();
        int st;
        st = 0;
        exp_c.delete(); exp_b.delete(); exp_t.delete();
        for (int i = 0; i < fq.size(); i++) begin
            int    t;
            int    c;
            string tg;
            t = i + 1;
            c = 0;
            if (st == 0) begin
                if (t <= SKIP) begin
                    tg = "R1";
                end else if (t <= SKIP + ALT) begin
                    tg = (t == SKIP + 1) ? "R3" : "R2";
                    if (t >= SKIP + 2 && fq[i] == fq[i-1]) begin
                        c = 3; st = 2;
                    end
                end else begin
                    tg = "R4";
                    if (fq[i] == fq[i-1]) begin
                        if (fq[i]) begin c = 1; st = 1; end
                        else begin c = 3; st = 2; tg = "R5"; end
                    end
                end
            end else if (st == 1) begin
                c = 2; tg = "R6";
            end else begin
                tg = "R7";
            end
            exp_c.push_back(c);
            exp_b.push_back(fq[i]);
            exp_t.push_back(tg);
        end
    endtask

    task automatic send_frame(input int gap);
        model();
        for (int i = 0; i < fq.size(); i++) begin
            @(negedge clk);
            if (i > 0) check_out(exp_c[i-1], exp_b[i-1], exp_t[i-1]);
            rx_valid = 1'b1;
            rx_bit   = fq[i];
        end
        @(negedge clk);
        check_out(exp_c[fq.size()-1], exp_b[fq.size()-1], exp_t[fq.size()-1]);
        rx_valid = 1'b0;
        rx_bit   = 1'($urandom);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check_out(0, 1'b0, "R8");
            rx_bit = 1'($urandom);
        end
        fq.delete();
    endtask

    task automatic add_rand(input int n);
        for (int i = 0; i < n; i++) fq.push_back(1'($urandom));
    endtask

    task automatic add_alt(input int n, input bit first);
        for (int i = 0; i < n; i++) fq.push_back(first ^ 1'(i & 1));
    endtask

    task automatic add_const(input int n, input bit v);
        for (int i = 0; i < n; i++) fq.push_back(v);
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R9: reset state
        repeat (3) @(negedge clk);
        check_out(0, 1'b0, "R9");
        rst = 1'b0;
        @(negedge clk);
        check_out(0, 1'b0, "R9");

        // R1: runs of equal bits in the settling window
        add_const(6, 1'b1); add_const(6, 1'b0); add_alt(4, 1'b1);
        add_alt(7, 1'b1); fq.push_back(1'b1); add_rand(10);
        send_frame(2);

        // R3: bit 16 equals bit 17
        add_rand(15); fq.push_back(1'b1); add_alt(6, 1'b1);
        fq.push_back(1'b1); add_rand(6);
        send_frame(2);

        // R2: bit 21 repeats bit 20
        add_rand(16); add_alt(4, 1'b0); fq.push_back(fq[fq.size()-1]);
        add_alt(6, 1'b1); fq.push_back(1'b1); add_rand(4);
        send_frame(1);

        // R4: earliest delimiter, bits 21 and 22
        add_rand(16); add_alt(5, 1'b1); fq.push_back(1'b1); add_rand(8);
        send_frame(1);

        // R5: two zeros while hunting
        add_rand(16); add_alt(8, 1'b1); add_const(2, 1'b0); add_rand(5);
        send_frame(1);

        // R7: valid-looking header after rejection is ignored
        add_rand(16); add_alt(3, 1'b1); fq.push_back(fq[fq.size()-1]);
        add_alt(10, 1'b1); add_const(2, 1'b1); add_rand(8);
        send_frame(1);

        // R8: single-cycle drop during payload, then a new frame
        add_rand(16); add_alt(6, 1'b0); fq.push_back(1'b1); add_rand(12);
        send_frame(0);
        add_rand(16); add_alt(5, 1'b1); fq.push_back(1'b1); add_rand(5);
        send_frame(0);

        // constrained random frames
        for (int k = 0; k < 150; k++) begin
            int alen;
            alen = 5 + int'($urandom_range(9));
            add_rand(SKIP);
            add_alt(alen, 1'($urandom));
            if ($urandom_range(9) < 7) begin
                if (!fq[fq.size()-1]) fq.push_back(1'b1);
                fq.push_back(1'b1);
            end else begin
                if (fq[fq.size()-1]) fq.push_back(1'b0);
                fq.push_back(1'b0);
            end
            add_rand(int'($urandom_range(20)));
            if ($urandom_range(9) == 0) begin
                int p;
                p = SKIP + int'($urandom_range(alen - 1));
                fq[p] = ~fq[p];
            end
            send_frame(int'($urandom_range(3)));
        end
        for (int k = 0; k < 20; k++) begin
            add_rand(40);
            send_frame(int'($urandom_range(2)));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule